// File: doc/BRIEF.md
# Bit-Rate Adapting Elastic Store

This block sits at the input of one multiplexer channel. It absorbs the small rate difference between an asynchronous channel bit stream and the fixed slot rate of the multiplexer. Incoming bits are written whenever the channel's write strobe fires. The multiplexer collects one bit per frame row by pulsing a slot strobe. The store tracks how many bits it holds. When that fill level drifts too low, it asks for a stuff: the multiplexer answers with a grant, and the granted slot carries a dummy bit without consuming anything. When the fill level drifts too high, it asks for a spill: on the granted slot it hands out two bits, one on the normal data output and the next on a separate spill output meant for the overhead channel.

Each granted operation shifts the stream by exactly one bit. The multiplexer services at most one channel per major frame, so a request may wait several frames for its grant. For that reason a request is held until it is serviced and is only re-evaluated afterwards. A request therefore never covers a grant twice.

The store has 16 entries by default, starts half full of zero bits, requests a stuff at four or fewer entries and a spill at twelve or more. Everything runs on one system clock, and the two strobes stand in for the two bit clocks.

Top module: `rate_adapt_store`

## Requirements
- R1: After reset the store holds DEPTH/2 (8) zero bits, both requests are low and out_valid, out_dummy, spill_valid, out_bit and spill_bit are 0.
- R2: A bit presented with wr_en is stored. Each rd_slot pulse produces out_valid exactly one cycle later, with the oldest stored bit on out_bit, in first-in first-out order.
- R3: A write that arrives while the store holds 16 bits, and no bit leaves in that cycle, is dropped.
- R4: An rd_slot while the store is empty, without a granted stuff, gives out_dummy=1 and out_bit=0 one cycle later and consumes nothing.
- R5: With no request held, stuff_req rises one cycle after the fill level becomes 4 or less, and spill_req rises one cycle after it becomes 12 or more. The two are never high together.
- R6: A raised request stays high until a matching grant is taken. It is low in the cycle after that grant and is re-evaluated from the fill level in the cycle after that.
- R7: rd_slot with grant_valid=1 and grant_spill=0 while stuff_req is high gives out_dummy=1, out_bit=0 and spill_valid=0 one cycle later, and consumes no stored bit.
- R8: rd_slot with grant_valid=1 and grant_spill=1 while spill_req is high and at least 2 bits are held consumes two bits. One cycle later the older one is on out_bit, the next one is on spill_bit, and spill_valid=1.
- R9: A grant whose type does not match the held request, or a grant given without rd_slot, has no effect: the slot is read normally and the request stays high.
- R10: With input rates 0.3% above and 0.3% below the slot rate and grants given as requested, the output bits with dummy slots removed and spill bits placed after their slot's data bit equal the written stream, preceded by the 8 reset zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Channel write strobe |
| wr_bit | input | 1 | Channel data bit |
| rd_slot | input | 1 | Multiplexer read strobe, one per frame row |
| grant_valid | input | 1 | Service grant for this slot |
| grant_spill | input | 1 | Grant type: 0 stuff, 1 spill |
| stuff_req | output | 1 | Request to insert a dummy bit |
| spill_req | output | 1 | Request to send one extra bit |
| out_valid | output | 1 | Slot result valid |
| out_bit | output | 1 | Slot data bit |
| out_dummy | output | 1 | Slot carries a dummy bit |
| spill_valid | output | 1 | Spill bit valid |
| spill_bit | output | 1 | Extra bit for the overhead channel |

## Verification
Slot results appear on the edge that follows the rd_slot cycle. The bench therefore reads them at the next falling edge after driving a slot, inside the same step. The fill level changes on the edge that takes a write or a slot, and a request follows one edge later. Request checks are taken after one extra idle step, and also after one step where the window is meant to be still closed. The stream sweeps at both rate offsets check every slot result in the step right after it, against a queue of written bits and the grants the bench itself issued.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam logic [1:0] POP_NONE = 2'd0;
  localparam logic [1:0] POP_ONE  = 2'd1;
  localparam logic [1:0] POP_TWO  = 2'd2;

  // Number of stored bits a slot consumes.
  function automatic logic [1:0] slot_pop(input logic slot, input logic stuff_go,
                                          input logic spill_go, input logic empty);
    if (!slot || stuff_go || empty) return POP_NONE;
    if (spill_go) return POP_TWO;
    return POP_ONE;
  endfunction

  function automatic logic at_low_water(input int unsigned level, input int unsigned mark);
    return level <= mark;
  endfunction

  function automatic logic at_high_water(input int unsigned level, input int unsigned mark);
    return level >= mark;
  endfunction
endpackage

// File: rtl/ras_ring.sv
module ras_ring #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         push_bit,
  input  logic [1:0]                   pop,
  output logic                         head0,
  output logic                         head1,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DEPTH-1:0] mem;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] level_q;
  logic [CNT_W:0]   after_pop;
  logic             push_ok;

  assign after_pop = {1'b0, level_q} - (CNT_W+1)'(pop);
  assign push_ok   = push && (after_pop < (CNT_W+1)'(DEPTH));
  assign head0     = mem[rd_ptr];
  assign head1     = mem[rd_ptr + PTR_W'(1)];
  assign level     = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem     <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= PTR_W'(DEPTH/2);
      level_q <= CNT_W'(DEPTH/2);
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= push_bit;
        wr_ptr      <= wr_ptr + PTR_W'(1);
      end
      rd_ptr  <= rd_ptr + PTR_W'(pop);
      level_q <= CNT_W'(after_pop + (CNT_W+1)'(push_ok));
    end
  end
endmodule

// File: rtl/ras_req_ctrl.sv
module ras_req_ctrl #(
  parameter int CNT_W     = 5,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic             serviced,
  output logic             stuff_req,
  output logic             spill_req
);
  import ras_pkg::*;

  logic held;
  assign held = stuff_req || spill_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stuff_req <= 1'b0;
      spill_req <= 1'b0;
    end else if (serviced) begin
      stuff_req <= 1'b0;
      spill_req <= 1'b0;
    end else if (!held) begin
      stuff_req <= at_low_water(int'(level), LOW_MARK);
      spill_req <= at_high_water(int'(level), HIGH_MARK);
    end
  end
endmodule

// File: rtl/ras_out_stage.sv
module ras_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot,
  input  logic [1:0] pop,
  input  logic       head0,
  input  logic       head1,
  output logic       out_valid,
  output logic       out_bit,
  output logic       out_dummy,
  output logic       spill_valid,
  output logic       spill_bit
);
  import ras_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_bit     <= 1'b0;
      out_dummy   <= 1'b0;
      spill_valid <= 1'b0;
      spill_bit   <= 1'b0;
    end else begin
      out_valid   <= slot;
      out_bit     <= slot && (pop != POP_NONE) && head0;
      out_dummy   <= slot && (pop == POP_NONE);
      spill_valid <= (pop == POP_TWO);
      spill_bit   <= (pop == POP_TWO) && head1;
    end
  end
endmodule

// File: rtl/rate_adapt_store.sv
module rate_adapt_store #(
  parameter int DEPTH     = 16,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_slot,
  input  logic grant_valid,
  input  logic grant_spill,
  output logic stuff_req,
  output logic spill_req,
  output logic out_valid,
  output logic out_bit,
  output logic out_dummy,
  output logic spill_valid,
  output logic spill_bit
);
  import ras_pkg::*;

  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] level;
  logic             head0, head1;
  logic             is_empty;
  logic             do_stuff, do_spill, serviced;
  logic [1:0]       pop_cnt;

  assign is_empty = (level == '0);
  assign do_stuff = rd_slot && grant_valid && !grant_spill && stuff_req;
  assign do_spill = rd_slot && grant_valid && grant_spill && spill_req
                    && (level >= CNT_W'(2));
  assign serviced = do_stuff || do_spill;
  assign pop_cnt  = slot_pop(rd_slot, do_stuff, do_spill, is_empty);

  ras_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_bit(wr_bit),
    .pop(pop_cnt), .head0(head0), .head1(head1), .level(level)
  );

  ras_req_ctrl #(.CNT_W(CNT_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_req (
    .clk(clk), .rst_n(rst_n), .level(level), .serviced(serviced),
    .stuff_req(stuff_req), .spill_req(spill_req)
  );

  ras_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .slot(rd_slot), .pop(pop_cnt),
    .head0(head0), .head1(head1), .out_valid(out_valid), .out_bit(out_bit),
    .out_dummy(out_dummy), .spill_valid(spill_valid), .spill_bit(spill_bit)
  );
endmodule

// File: rtl/rate_adapt_store_chk.sv
module rate_adapt_store_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_slot,
  input logic                       grant_valid,
  input logic                       grant_spill,
  input logic                       stuff_req,
  input logic                       spill_req,
  input logic                       out_valid,
  input logic                       out_dummy,
  input logic                       spill_valid,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stuff_req && spill_req));

  assert_slot_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot |=> out_valid);

  assert_no_stray_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_slot |=> !out_valid);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));

  assert_empty_slot_dummy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_slot && level == '0) |=> out_dummy);

  assert_stuff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_req && !(rd_slot && grant_valid && !grant_spill)) |=> stuff_req);

  assert_spill_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_req && !(rd_slot && grant_valid && grant_spill)) |=> spill_req);

  assert_stuff_keeps_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_slot && grant_valid && !grant_spill && stuff_req && !wr_en) |=> $stable(level));

  assert_dummy_no_spill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_dummy |-> !spill_valid);

  assert_spill_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid |-> $past(rd_slot && grant_valid && grant_spill && spill_req));
endmodule

bind rate_adapt_store rate_adapt_store_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_slot(rd_slot),
  .grant_valid(grant_valid), .grant_spill(grant_spill),
  .stuff_req(stuff_req), .spill_req(spill_req), .out_valid(out_valid),
  .out_dummy(out_dummy), .spill_valid(spill_valid), .level(level)
);

// File: tb/rate_adapt_store_tb.sv
`timescale 1ns/1ps
module rate_adapt_store_tb;
  localparam int DEPTH = 16;
  localparam int ROW   = 16;
  localparam int ROWS  = 3000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wr_en, wr_bit, rd_slot, grant_valid, grant_spill;
  logic stuff_req, spill_req, out_valid, out_bit, out_dummy, spill_valid, spill_bit;

  rate_adapt_store u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_slot(rd_slot),
    .grant_valid(grant_valid), .grant_spill(grant_spill), .stuff_req(stuff_req),
    .spill_req(spill_req), .out_valid(out_valid), .out_bit(out_bit),
    .out_dummy(out_dummy), .spill_valid(spill_valid), .spill_bit(spill_bit)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic exp_q[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic wb, input logic s,
                      input logic gv, input logic gs);
    wr_en = w; wr_bit = wb; rd_slot = s; grant_valid = gv; grant_spill = gs;
    if (w) exp_q.push_back(wb);
    @(negedge clk);
    wr_en = 0; rd_slot = 0; grant_valid = 0; grant_spill = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; wr_bit = 0; rd_slot = 0; grant_valid = 0; grant_spill = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_q = {};
    for (int i = 0; i < DEPTH/2; i++) exp_q.push_back(1'b0);
  endtask

  // Check a slot result that became visible at this falling edge.
  task automatic check_slot(input string tag, input bit exp_dummy, input bit exp_spill);
    logic b;
    chk({tag, " out_valid"}, out_valid, 1);
    chk({tag, " out_dummy"}, out_dummy, exp_dummy);
    if (exp_dummy) chk({tag, " dummy bit"}, out_bit, 0);
    else if (exp_q.size() == 0) chk({tag, " queue empty"}, 1, 0);
    else begin b = exp_q.pop_front(); chk({tag, " out_bit"}, out_bit, b); end
    chk({tag, " spill_valid"}, spill_valid, exp_spill);
    if (exp_spill) begin
      if (exp_q.size() == 0) chk({tag, " spill queue empty"}, 1, 0);
      else begin b = exp_q.pop_front(); chk({tag, " spill_bit"}, spill_bit, b); end
    end
  endtask

  task automatic stream(input int rate, input bit fast);
    int acc = 0;
    int stuffs = 0;
    int spills = 0;
    bit pend_stuff = 0;
    bit pend_spill = 0;
    bit pend_slot = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic w, s, gv, gs;
    do_reset();
    for (int cyc = 0; cyc < ROWS*ROW; cyc++) begin
      if (pend_slot) check_slot("R10", pend_stuff, pend_spill);
      else chk("R10 idle out_valid", out_valid, 0);
      acc += rate;
      w = 0;
      if (acc >= 16000) begin acc -= 16000; w = 1; end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s  = (cyc % ROW == 0);
      gv = s && ((cyc / ROW) % 32 == 0) && (stuff_req || spill_req);
      gs = spill_req;
      pend_slot  = s;
      pend_stuff = gv && !gs;
      pend_spill = gv && gs;
      if (pend_stuff) stuffs++;
      if (pend_spill) spills++;
      step(w, lfsr[0], s, gv, gs);
    end
    if (pend_slot) check_slot("R10", pend_stuff, pend_spill);
    if (fast) begin
      chk("R10 spills taken at fast rate", spills > 0, 1);
      chk("R10 no stuffs at fast rate", stuffs, 0);
    end else begin
      chk("R10 stuffs taken at slow rate", stuffs > 0, 1);
      chk("R10 no spills at slow rate", spills, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    do_reset();
    chk("R1 stuff_req", stuff_req, 0);
    chk("R1 spill_req", spill_req, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_dummy", out_dummy, 0);
    chk("R1 spill_valid", spill_valid, 0);
    chk("R1 out_bit", out_bit, 0);

    // R2/R5: drain prefill, stuff window
    for (int i = 0; i < 3; i++) begin step(0, 0, 1, 0, 0); check_slot("R2", 0, 0); end
    step(0, 0, 0, 0, 0);
    chk("R5 stuff_req at level 5", stuff_req, 0);
    step(0, 0, 1, 0, 0); check_slot("R2", 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5 stuff_req at level 4", stuff_req, 1);
    chk("R5 spill_req low", spill_req, 0);
    // R9: mismatched grant and grant without slot
    step(0, 0, 1, 1, 1); check_slot("R9 mismatched grant", 0, 0);
    chk("R9 stuff_req kept", stuff_req, 1);
    step(0, 0, 0, 1, 0);
    chk("R9 grant without slot", stuff_req, 1);
    // R7/R6: stuff grant
    step(0, 0, 1, 1, 0); check_slot("R7", 1, 0);
    chk("R6 stuff_req cleared after grant", stuff_req, 0);
    step(0, 0, 0, 0, 0);
    chk("R6 stuff_req re-evaluated", stuff_req, 1);
    for (int i = 0; i < 3; i++) begin step(0, 0, 1, 0, 0); check_slot("R2", 0, 0); end
    step(0, 0, 1, 0, 0); check_slot("R4 empty slot", 1, 0);

    // R5/R3: fill, spill window, overflow drop
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5 spill_req at level 11", spill_req, 0);
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5 spill_req at level 12", spill_req, 1);
    chk("R5 stuff_req low", stuff_req, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0); void'(exp_q.pop_back());
    step(1, 0, 0, 0, 0); void'(exp_q.pop_back());
    for (int i = 0; i < DEPTH; i++) begin step(0, 0, 1, 0, 0); check_slot("R3", 0, 0); end
    step(0, 0, 1, 0, 0); check_slot("R3 drop left store empty", 1, 0);

    // R8/R6: spill grant after a held request
    do_reset();
    step(1, 1, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5 spill_req raised", spill_req, 1);
    for (int i = 0; i < 7; i++) begin step(0, 0, 1, 0, 0); check_slot("R2", 0, 0); end
    chk("R6 spill_req held at level 5", spill_req, 1);
    step(0, 0, 1, 1, 1); check_slot("R8", 0, 1);
    chk("R6 spill_req cleared after grant", spill_req, 0);
    for (int i = 0; i < 3; i++) begin step(0, 0, 1, 0, 0); check_slot("R8 order after spill", 0, 0); end
    step(0, 0, 1, 0, 0); check_slot("R4 empty after spill", 1, 0);

    // R10: rate sweeps
    stream(1003, 1);
    stream(997, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule